// File: doc/BRIEF.md
# Conflict-Avoiding Round-Robin Switch Allocator

This block decides, once per clock, which virtual channels of a five-port router may push a flit across the crossbar in the next cycle. Every input port presents four virtual-channel request slots. Each slot has a valid bit and the output port that route computation picked for it. The allocator hands at most one grant to each input and at most one grant to each output. The result is a five-flit window with at most one flit per output.

Inputs are visited in a fixed order, lowest index first, against a shared record of outputs that are already taken. Each input has its own round-robin pointer. The allocator does not stall an input whose preferred VC collides with an output granted earlier in the same pass. Instead it skips that VC and offers the next VC of the same input. An output with no winner is reported empty. The per-output record (source input and source VC) is registered and drives the crossbar select lines in the following cycle. The per-input one-hot grant vector is registered alongside it.

Top module: `vc_switch_alloc`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `grant_vc` and `out_vld` are all zero. Every round-robin pointer restarts at VC 0.
- R2: Each input receives at most one granted VC per cycle. `grant_vc` bit i*4+v stands for VC v of input i.
- R3: Each output is granted at most once per cycle. When `out_vld[o]` is set, `out_src_port` field o (bits 3o+2..3o) and `out_src_vc` field o (bits 2o+1..2o) name a VC that is granted in `grant_vc` and that requested output o. The number of set `out_vld` bits equals the number of set `grant_vc` bits.
- R4: A VC is granted only if, in the previous cycle, its valid bit was set and its destination field (bits (i*4+v)*3+2..(i*4+v)*3 of `req_dst`) held an in-range output.
- R5: Inputs claim outputs in ascending order. When several inputs contend for one output, the lowest-numbered input wins, unless that input takes a different output first.
- R6: If an input's round-robin candidate targets an output that is already taken, that VC is skipped. The next VC of the same input, in round-robin order, is tried instead. An input is left without a grant only when every one of its valid VCs targets a taken output.
- R7: After an input is granted VC v, its pointer moves to VC (v+1) mod 4. When the input gets no grant, its pointer does not move.
- R8: A VC of an input that keeps requesting, and whose output is never taken by a lower-numbered input, is granted within any 4 consecutive cycles.
- R9: The output record is rebuilt every cycle. Outputs with no winner show `out_vld` low, and a cycle with no valid request yields no grant at all.
- R10: A request whose destination value is 5 or more is treated as not valid.
- R11: Grants reflect the requests sampled at the preceding clock edge, so the outputs lag the requests by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 20 | Request valid, bit i*4+v for VC v of input i |
| req_dst | input | 60 | Requested output, 3 bits per VC slot |
| grant_vc | output | 20 | Registered one-hot-per-input grant vector |
| out_vld | output | 5 | Output o has a winner next cycle |
| out_src_port | output | 15 | Winning input for each output, 3 bits per output |
| out_src_vc | output | 10 | Winning VC for each output, 2 bits per output |

## Verification
The bench builds the block with its default size of five ports, four VCs per port and 3-bit destination fields. This setting covers every contention shape between inputs. It also leaves three unused destination codes (5, 6 and 7), which exercise the out-of-range rule. A nested sweep enumerates all 256 combinations of VC valid masks on two inputs that deliberately overlap their outputs. A long pseudo-random run then covers all five inputs, with the bench following pointer state through its own model. Directed sequences pin down pointer advance, pointer hold under full blocking, and rotation across a persistent four-VC request.

// File: rtl/sa_pkg.sv
package sa_pkg;

  // width of an index able to address n items (at least one bit)
  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // circular advance of a position inside a ring of size n
  function automatic int ring_add(int base, int off, int n);
    return (base + off) % n;
  endfunction

endpackage

// File: rtl/sa_vc_picker.sv
module sa_vc_picker
  import sa_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int NUM_VCS   = 4,
  parameter int DST_W     = 3,
  localparam int VW       = idx_w(NUM_VCS)
) (
  input  logic [VW-1:0]            ptr,
  input  logic [NUM_VCS-1:0]       vld,
  input  logic [NUM_VCS*DST_W-1:0] dst,
  input  logic [NUM_PORTS-1:0]     taken_in,
  output logic [NUM_VCS-1:0]       gnt,
  output logic [VW-1:0]            gnt_idx,
  output logic                     gnt_any,
  output logic [DST_W-1:0]         gnt_dst,
  output logic [NUM_PORTS-1:0]     taken_out
);

  localparam int DSPAN = 1 << DST_W;

  logic [DSPAN-1:0] tk_in_ext;
  logic [DSPAN-1:0] tk_out_ext;

  assign tk_in_ext = DSPAN'(taken_in);

  // scan VCs starting at the pointer; first valid, in-range, free one wins
  always_comb begin
    gnt        = '0;
    gnt_idx    = '0;
    gnt_any    = 1'b0;
    gnt_dst    = '0;
    tk_out_ext = tk_in_ext;
    for (int k = 0; k < NUM_VCS; k++) begin : scan
      int               c;
      logic [DST_W-1:0] d;
      c = ring_add(int'(ptr), k, NUM_VCS);
      d = dst[c*DST_W +: DST_W];
      if (!gnt_any && vld[c] && (int'(d) < NUM_PORTS) && !tk_in_ext[d]) begin
        gnt_any       = 1'b1;
        gnt[c]        = 1'b1;
        gnt_idx       = VW'(c);
        gnt_dst       = d;
        tk_out_ext[d] = 1'b1;
      end
    end
  end

  assign taken_out = tk_out_ext[NUM_PORTS-1:0];

endmodule

// File: rtl/sa_rr_ptr.sv
module sa_rr_ptr
  import sa_pkg::*;
#(
  parameter int NUM_VCS = 4,
  localparam int VW     = idx_w(NUM_VCS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [VW-1:0] won_idx,
  output logic [VW-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= VW'(ring_add(int'(won_idx), 1, NUM_VCS));
    end
  end

endmodule

// File: rtl/sa_out_record.sv
module sa_out_record
  import sa_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int NUM_VCS   = 4,
  parameter int DST_W     = 3,
  localparam int VW       = idx_w(NUM_VCS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_PORTS*NUM_VCS-1:0] gnt_flat,
  input  logic [NUM_PORTS-1:0]         any_in,
  input  logic [NUM_PORTS*DST_W-1:0]   dst_in,
  input  logic [NUM_PORTS*VW-1:0]      idx_in,
  output logic [NUM_PORTS*NUM_VCS-1:0] grant_vc,
  output logic [NUM_PORTS-1:0]         out_vld,
  output logic [NUM_PORTS*DST_W-1:0]   out_src_port,
  output logic [NUM_PORTS*VW-1:0]      out_src_vc
);

  localparam int DSPAN = 1 << DST_W;

  logic [DSPAN-1:0]       rec_vld;
  logic [DSPAN*DST_W-1:0] rec_port;
  logic [DSPAN*VW-1:0]    rec_vc;

  // scatter per-input winners onto the output they claimed
  always_comb begin
    rec_vld  = '0;
    rec_port = '0;
    rec_vc   = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin : scatter
      logic [DST_W-1:0] d;
      d = dst_in[i*DST_W +: DST_W];
      if (any_in[i]) begin
        rec_vld[d]                 = 1'b1;
        rec_port[d*DST_W +: DST_W] = DST_W'(i);
        rec_vc[d*VW +: VW]         = idx_in[i*VW +: VW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_vc     <= '0;
      out_vld      <= '0;
      out_src_port <= '0;
      out_src_vc   <= '0;
    end else begin
      grant_vc     <= gnt_flat;
      out_vld      <= rec_vld[NUM_PORTS-1:0];
      out_src_port <= rec_port[NUM_PORTS*DST_W-1:0];
      out_src_vc   <= rec_vc[NUM_PORTS*VW-1:0];
    end
  end

endmodule

// File: rtl/vc_switch_alloc.sv
module vc_switch_alloc
  import sa_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int NUM_VCS   = 4,
  parameter int DST_W     = idx_w(NUM_PORTS),
  localparam int VW       = idx_w(NUM_VCS),
  localparam int NREQ     = NUM_PORTS * NUM_VCS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NREQ-1:0]            req_vld,
  input  logic [NREQ*DST_W-1:0]      req_dst,
  output logic [NREQ-1:0]            grant_vc,
  output logic [NUM_PORTS-1:0]       out_vld,
  output logic [NUM_PORTS*DST_W-1:0] out_src_port,
  output logic [NUM_PORTS*VW-1:0]    out_src_vc
);

  logic [NUM_PORTS-1:0]       taken_chain [NUM_PORTS+1];
  logic [NREQ-1:0]            gnt_flat;
  logic [NUM_PORTS-1:0]       any_in;
  logic [NUM_PORTS*DST_W-1:0] dst_in;
  logic [NUM_PORTS*VW-1:0]    idx_in;

  assign taken_chain[0] = '0;

  // inputs claim outputs in ascending order through the taken chain
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
    logic [VW-1:0] ptr;

    sa_rr_ptr #(.NUM_VCS(NUM_VCS)) u_ptr (
      .clk     (clk),
      .rst     (rst),
      .adv     (any_in[i]),
      .won_idx (idx_in[i*VW +: VW]),
      .ptr     (ptr)
    );

    sa_vc_picker #(
      .NUM_PORTS (NUM_PORTS),
      .NUM_VCS   (NUM_VCS),
      .DST_W     (DST_W)
    ) u_pick (
      .ptr       (ptr),
      .vld       (req_vld[i*NUM_VCS +: NUM_VCS]),
      .dst       (req_dst[i*NUM_VCS*DST_W +: NUM_VCS*DST_W]),
      .taken_in  (taken_chain[i]),
      .gnt       (gnt_flat[i*NUM_VCS +: NUM_VCS]),
      .gnt_idx   (idx_in[i*VW +: VW]),
      .gnt_any   (any_in[i]),
      .gnt_dst   (dst_in[i*DST_W +: DST_W]),
      .taken_out (taken_chain[i+1])
    );
  end

  sa_out_record #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_VCS   (NUM_VCS),
    .DST_W     (DST_W)
  ) u_rec (
    .clk          (clk),
    .rst          (rst),
    .gnt_flat     (gnt_flat),
    .any_in       (any_in),
    .dst_in       (dst_in),
    .idx_in       (idx_in),
    .grant_vc     (grant_vc),
    .out_vld      (out_vld),
    .out_src_port (out_src_port),
    .out_src_vc   (out_src_vc)
  );

endmodule

// File: rtl/sa_alloc_checker.sv
module sa_alloc_checker
  import sa_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int NUM_VCS   = 4,
  parameter int DST_W     = 3,
  localparam int VW       = idx_w(NUM_VCS),
  localparam int NREQ     = NUM_PORTS * NUM_VCS
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NREQ-1:0]            req_vld,
  input logic [NREQ*DST_W-1:0]      req_dst,
  input logic [NREQ-1:0]            grant_vc,
  input logic [NUM_PORTS-1:0]       out_vld,
  input logic [NUM_PORTS*DST_W-1:0] out_src_port,
  input logic [NUM_PORTS*VW-1:0]    out_src_vc
);

  logic [NREQ-1:0]       vld_q;
  logic [NREQ*DST_W-1:0] dst_q;
  logic [NUM_PORTS-1:0]  src_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      dst_q <= '0;
    end else begin
      vld_q <= req_vld;
      dst_q <= req_dst;
    end
  end

  // for each output, the recorded source is granted and asked for that output
  always_comb begin
    src_ok = '0;
    for (int o = 0; o < NUM_PORTS; o++) begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        for (int v = 0; v < NUM_VCS; v++) begin
          if (int'(out_src_port[o*DST_W +: DST_W]) == i &&
              int'(out_src_vc[o*VW +: VW]) == v &&
              grant_vc[i*NUM_VCS+v] && vld_q[i*NUM_VCS+v] &&
              int'(dst_q[(i*NUM_VCS+v)*DST_W +: DST_W]) == o)
            src_ok[o] = 1'b1;
        end
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (grant_vc == '0 && out_vld == '0)); // R1

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (rst)
    $countones(grant_vc) == $countones(out_vld)); // R3

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (vld_q == '0) |-> (grant_vc == '0 && out_vld == '0)); // R9

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in_chk
    AST_ONE_VC_PER_INPUT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant_vc[i*NUM_VCS +: NUM_VCS])); // R2
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out_chk
    AST_OUT_SOURCE_VALID: assert property (@(posedge clk) disable iff (rst)
      out_vld[o] |-> src_ok[o]); // R3
  end

  for (genvar b = 0; b < NREQ; b++) begin : g_req_chk
    AST_GRANT_WAS_REQUESTED: assert property (@(posedge clk) disable iff (rst)
      grant_vc[b] |-> vld_q[b]); // R4
    AST_RANGE_IGNORED: assert property (@(posedge clk) disable iff (rst)
      grant_vc[b] |-> (int'(dst_q[b*DST_W +: DST_W]) < NUM_PORTS)); // R10
  end

endmodule

bind vc_switch_alloc sa_alloc_checker #(
  .NUM_PORTS (NUM_PORTS),
  .NUM_VCS   (NUM_VCS),
  .DST_W     (DST_W)
) u_sa_chk (
  .clk          (clk),
  .rst          (rst),
  .req_vld      (req_vld),
  .req_dst      (req_dst),
  .grant_vc     (grant_vc),
  .out_vld      (out_vld),
  .out_src_port (out_src_port),
  .out_src_vc   (out_src_vc)
);

// File: tb/test_vc_switch_alloc.sv
module test_vc_switch_alloc;

  localparam int P  = 5;
  localparam int V  = 4;
  localparam int DW = 3;
  localparam int VW = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [P*V-1:0]    req_vld = '0;
  logic [P*V*DW-1:0] req_dst = '0;
  logic [P*V-1:0]    grant_vc;
  logic [P-1:0]      out_vld;
  logic [P*DW-1:0]   out_src_port;
  logic [P*VW-1:0]   out_src_vc;

  int n_chk  = 0;
  int n_fail = 0;
  int ptr_m [P];
  logic rv [P][V];
  int   rd [P][V];
  logic [31:0] lfsr = 32'hACE1_2468;

  always #10 clk = ~clk;

  vc_switch_alloc i_vc_switch_alloc (
    .clk          (clk),
    .rst          (rst),
    .req_vld      (req_vld),
    .req_dst      (req_dst),
    .grant_vc     (grant_vc),
    .out_vld      (out_vld),
    .out_src_port (out_src_port),
    .out_src_vc   (out_src_vc)
  );

  task automatic cmp(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_req();
    for (int i = 0; i < P; i++)
      for (int v = 0; v < V; v++) begin
        rv[i][v] = 1'b0;
        rd[i][v] = 0;
      end
  endtask

  function automatic logic [31:0] lfsr_next(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // drive current request table, predict, wait one cycle, compare
  task automatic run_cycle(string tag);
    logic [P*V-1:0]  e_g;
    logic [P-1:0]    e_ov;
    logic [P-1:0]    taken;
    int              e_sp [P];
    int              e_sv [P];
    for (int i = 0; i < P; i++)
      for (int v = 0; v < V; v++) begin
        req_vld[i*V+v] = rv[i][v];
        req_dst[(i*V+v)*DW +: DW] = DW'(rd[i][v]);
      end
    e_g = '0; e_ov = '0; taken = '0;
    for (int o = 0; o < P; o++) begin e_sp[o] = 0; e_sv[o] = 0; end
    for (int i = 0; i < P; i++) begin
      int won;
      won = -1;
      for (int k = 0; k < V; k++) begin
        int c;
        c = (ptr_m[i] + k) % V;
        if (won < 0 && rv[i][c] && rd[i][c] < P && !taken[rd[i][c]]) won = c;
      end
      if (won >= 0) begin
        taken[rd[i][won]] = 1'b1;
        e_g[i*V+won] = 1'b1;
        e_ov[rd[i][won]] = 1'b1;
        e_sp[rd[i][won]] = i;
        e_sv[rd[i][won]] = won;
        ptr_m[i] = (won + 1) % V;
      end
    end
    @(negedge clk);
    cmp(tag, "grant_vc", int'(grant_vc), int'(e_g));
    cmp(tag, "out_vld", int'(out_vld), int'(e_ov));
    for (int o = 0; o < P; o++)
      if (e_ov[o]) begin
        cmp(tag, "out_src_port", int'(out_src_port[o*DW +: DW]), e_sp[o]);
        cmp(tag, "out_src_vc", int'(out_src_vc[o*VW +: VW]), e_sv[o]);
      end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [3:0] seen;
    for (int i = 0; i < P; i++) ptr_m[i] = 0;
    clear_req();
    repeat (3) @(negedge clk);
    cmp("R1", "grant_vc in reset", int'(grant_vc), 0);
    cmp("R1", "out_vld in reset", int'(out_vld), 0);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1", "grant_vc after reset", int'(grant_vc), 0);

    // R9: idle table yields nothing
    run_cycle("R9");

    // R5: three inputs want output 2, input 0 wins
    clear_req();
    rv[0][0] = 1; rd[0][0] = 2;
    rv[1][0] = 1; rd[1][0] = 2;
    rv[4][0] = 1; rd[4][0] = 2;
    run_cycle("R5");
    cmp("R5", "winner port of out2", int'(out_src_port[2*DW +: DW]), 0);
    cmp("R5", "input1 grant", int'(grant_vc[4 +: 4]), 0);

    // R11: requests removed, grants gone one cycle later
    clear_req();
    run_cycle("R11");
    cmp("R11", "grant cleared", int'(grant_vc), 0);

    // R6: input1 VC0 collides with input0, VC1 is taken instead
    clear_req();
    rv[0][1] = 1; rd[0][1] = 1;
    rv[1][0] = 1; rd[1][0] = 1;
    rv[1][1] = 1; rd[1][1] = 3;
    run_cycle("R6");
    cmp("R6", "input1 skips to VC1", int'(grant_vc[4 +: 4]), 4'b0010);
    cmp("R6", "out3 source vc", int'(out_src_vc[3*VW +: VW]), 1);

    // R10: out-of-range destinations are ignored
    clear_req();
    rv[2][0] = 1; rd[2][0] = 5;
    rv[2][1] = 1; rd[2][1] = 7;
    rv[2][2] = 1; rd[2][2] = 6;
    run_cycle("R10");
    cmp("R10", "no grant", int'(grant_vc), 0);
    cmp("R10", "no output", int'(out_vld), 0);

    // R7: advance past granted VC, hold while fully blocked
    clear_req();
    rv[3][2] = 1; rd[3][2] = 4;
    run_cycle("R7");
    clear_req();
    rv[0][0] = 1; rd[0][0] = 0;
    for (int v = 0; v < V; v++) begin rv[3][v] = 1; rd[3][v] = 0; end
    run_cycle("R7");
    cmp("R7", "blocked input3 no grant", int'(grant_vc[12 +: 4]), 0);
    clear_req();
    for (int v = 0; v < V; v++) begin rv[3][v] = 1; rd[3][v] = v; end
    run_cycle("R7");
    cmp("R7", "pointer held at VC3", int'(grant_vc[12 +: 4]), 4'b1000);

    // R8: persistent four-VC request rotates through all VCs
    seen = '0;
    for (int n = 0; n < V; n++) begin
      run_cycle("R8");
      seen = seen | grant_vc[12 +: 4];
    end
    cmp("R8", "all VCs served in 4 cycles", int'(seen), 4'hF);

    // R6 sweep: every valid-mask pair on two overlapping inputs
    for (int m = 0; m < 256; m++) begin
      clear_req();
      for (int v = 0; v < V; v++) begin
        rv[0][v] = m[v];     rd[0][v] = v;
        rv[1][v] = m[4+v];   rd[1][v] = (v + 1) % V;
      end
      run_cycle("R6");
    end

    // R2/R3/R4 pseudo-random sweep across all inputs
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < P; i++)
        for (int v = 0; v < V; v++) begin
          lfsr = lfsr_next(lfsr);
          rv[i][v] = lfsr[0] | lfsr[5];
          lfsr = lfsr_next(lfsr);
          rd[i][v] = lfsr[3] ? int'(lfsr[9:7]) : int'(lfsr[9:7]) % P;
        end
      run_cycle((n % 3 == 0) ? "R2" : ((n % 3 == 1) ? "R3" : "R4"));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule